// File: doc/BRIEF.md
# Marker-Coded Word Unpacker

This block turns a stream of 32-bit words back into the byte stream they were packed from. Each word carries one to four data bytes. The number of bytes is not sent on a separate length field. It is coded in the upper bytes of the word itself: fixed marker values fill the unused byte lanes.

The block takes a word over a valid/ready port and finds how many bytes it holds. It then presents those bytes one at a time on a byte-wide valid/ready port, starting with the least significant byte. A flag marks the final byte of each word.

No new word is taken until the last byte of the current word has been accepted downstream. Backpressure on the byte side therefore stalls the word side. A synchronous reset drops any word that is only partly emitted.

Top module: `word_unpacker`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `out_valid` is 0 and `in_ready` is 1.
- R2: A word whose bits 31:8 equal 0x808080 yields exactly one byte, bits 7:0.
- R3: A word whose bits 31:16 equal 0x8181 yields exactly two bytes: bits 7:0, then bits 15:8.
- R4: A word whose bits 31:24 equal 0x82 yields exactly three bytes: bits 7:0, then 15:8, then 23:16.
- R5: Any word that matches none of the three marker patterns yields four bytes, with bits 31:24 last. This includes near-miss patterns such as 0x81808080 and 0x80818181.
- R6: The marker tests are applied in a fixed order: the one-byte pattern first, then the two-byte, then the three-byte.
- R7: `in_ready` is 1 only when no byte of the current word remains to be emitted. A word offered while bytes remain is not taken and has no effect on the output.
- R8: `out_last` is 1 on the final byte of each word and 0 on every other byte.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte` and `out_last` hold their values.
- R10: A reset in the middle of a word discards the bytes of that word that have not yet been emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 32 | Packed input word |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word |
| out_byte | output | 8 | Current output byte |
| out_valid | output | 1 | Output byte is valid |
| out_last | output | 1 | Output byte is the last one of its word |
| out_ready | input | 1 | Downstream takes the byte |

## Verification
The bench offers words that sit exactly on each marker pattern. It also offers words that miss a pattern by one byte, such as 0x81808080, 0x80818181 and 0x80808100. A classifier that compared too few bits would cut these words short. One that compared too many bits would emit extra marker bytes.

While the byte side is stalled, the bench offers a different word. A design that raised `in_ready` too early would overwrite the pending bytes.

The bench also asserts reset halfway through a word. A design that kept its count through reset would go on emitting stale bytes afterwards.

// File: rtl/word_unpacker.sv
module word_unpacker (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] in_word,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  out_byte,
  output logic        out_valid,
  output logic        out_last,
  input  logic        out_ready
);

  logic [31:0] hold_q;
  logic [2:0]  left_q;
  logic [2:0]  word_len;

  always_comb begin
    if (in_word[31:8] == 24'h808080)
      word_len = 3'd1;
    else if (in_word[31:16] == 16'h8181)
      word_len = 3'd2;
    else if (in_word[31:24] == 8'h82)
      word_len = 3'd3;
    else
      word_len = 3'd4;
  end

  assign in_ready  = (left_q == 3'd0);
  assign out_valid = (left_q != 3'd0);
  assign out_last  = (left_q == 3'd1);
  assign out_byte  = hold_q[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      left_q <= 3'd0;
    end else if (in_ready) begin
      if (in_valid) begin
        hold_q <= in_word;
        left_q <= word_len;
      end
    end else if (out_ready) begin
      hold_q <= {8'h00, hold_q[31:8]};
      left_q <= left_q - 3'd1;
    end
  end

endmodule

// File: rtl/word_unpacker_chk.sv
module word_unpacker_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] in_word,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  out_byte,
  input logic        out_valid,
  input logic        out_last,
  input logic        out_ready
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (in_ready && !out_valid)); // R1

  AST_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[31:8] == 24'h808080) |=> (out_valid && out_last)); // R2

  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && !in_ready)); // R7

  AST_MORE_AFTER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_valid && !in_ready)); // R8

  AST_LAST_FREES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R9

endmodule

bind word_unpacker word_unpacker_chk u_chk (.*);

// File: tb/word_unpacker_test.sv
`timescale 1ns/1ps
module word_unpacker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_last;
  logic        out_ready = 1'b1;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  word_unpacker uut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .out_byte(out_byte), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input string tag);
    @(negedge clk);
    chk(in_ready == 1'b1, {tag, " R7 idle ready"}, in_ready, 1);
    in_word  = w;
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(out_valid == 1'b1, {tag, " R6 valid"}, out_valid, 1);
      chk(out_byte == w[8*i +: 8], {tag, " R6 byte"}, out_byte, w[8*i +: 8]);
      chk(out_last == (i == n - 1), {tag, " R8 last"}, out_last, (i == n - 1));
      chk(in_ready == 1'b0, {tag, " R7 busy"}, in_ready, 0);
      @(negedge clk);
    end
    chk(out_valid == 1'b0, {tag, " count done"}, out_valid, 0);
    chk(in_ready == 1'b1, {tag, " R7 ready again"}, in_ready, 1);
  endtask

  task automatic test_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic test_markers;
    send_word(32'h80808041, 1, "R2 one");
    send_word(32'h80808000, 1, "R2 zero byte");
    send_word(32'h80808082, 1, "R6 one over three");
    send_word(32'h81814241, 2, "R3 two");
    send_word(32'h81818080, 2, "R3 two marker data");
    send_word(32'h82434241, 3, "R4 three");
    send_word(32'h82808080, 3, "R4 three marker data");
    send_word(32'h44434241, 4, "R5 plain");
    send_word(32'h81808080, 4, "R5 near two");
    send_word(32'h80818181, 4, "R5 near one");
    send_word(32'h80808100, 4, "R5 near one low");
  endtask

  task automatic test_stall;
    logic [31:0] w;
    w = 32'hA1B2C3D4;
    @(negedge clk);
    in_word = w;
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_word = 32'h80808055;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == 1'b1 && out_byte == 8'hD4, "R9 stall hold", {24'h0, out_byte}, 32'hD4);
      chk(in_ready == 1'b0, "R7 stall busy", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(out_byte == w[8*i +: 8], "R7 ignored word", out_byte, w[8*i +: 8]);
      chk(out_last == (i == 3), "R8 stall last", out_last, (i == 3));
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R7 no extra word", out_valid, 0);
  endtask

  task automatic test_mid_reset;
    @(negedge clk);
    in_word = 32'h11223344;
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_byte == 8'h44, "R10 first byte", out_byte, 8'h44);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R10 discarded", out_valid, 0);
    chk(in_ready == 1'b1, "R10 ready", in_ready, 1);
    send_word(32'h81816655, 2, "R10 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_markers();
    test_stall();
    test_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule